// File: doc/BRIEF.md
# DDR2 Extended Mode Register Sequencer

This block sits on the controller side of a DDR2 memory interface. It issues the register-set commands that program the second and third extended mode registers, and it decides when reads are allowed again after the memory's delay-locked loop (DLL) restarts. A requester offers one command at a time with a valid/ready handshake. The request names the target register and, for the second extended register, whether the high-temperature self-refresh rate is enabled. The block accepts the request only when the memory reports all banks precharged and the clock-enable pin is already high. It then drives chip select, the row and column strobes, write enable, the bank address and the fourteen address pins for exactly one clock cycle. After that it holds off further commands until the register-set spacing time has passed.

A separate tracker watches DLL events. A DLL enable/reset pulse, or an exit from self-refresh (which turns the DLL back on), starts a lockout of a fixed number of clock cycles. A new event during the lockout starts it again from the beginning. Entering self-refresh turns the DLL off, so reads are blocked until the memory leaves self-refresh and a full lockout has then elapsed. The read-permitted flag is low out of reset, because the second extended register has no defined value at power-up and initialization has to run first.

Top module: `ddr2_xmr_seq`

## Requirements
- R1: Out of reset `cs_n`, `ras_n`, `cas_n` and `we_n` are 1, `bank` and `addr` are 0, `busy` is 0 and `rd_ok` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. In the next cycle only, `cs_n`, `ras_n`, `cas_n` and `we_n` are all 0. In every other cycle all four are 1.
- R3: `req_sel` = 0 targets the second extended register and drives `bank` = 2'b10 (bank bit 1 high, bit 0 low). `req_sel` = 1 targets the third extended register and drives `bank` = 2'b11.
- R4: For the second extended register, `addr[7]` equals `req_hitemp` (1 enables the high-temperature self-refresh rate) and every other address bit is 0. For the third extended register all fourteen address bits are 0 whatever `req_hitemp` is. Outside a command cycle `addr` and `bank` are 0.
- R5: `req_ready` is 0 while `banks_idle` is 0 or `cke_high` is 0. A pending request is held and no command is issued until both inputs are 1.
- R6: `busy` is 1 from the command cycle for T_MRD-1 cycles, and `req_ready` is 0 while `busy` is 1. A request held during that time is issued exactly T_MRD cycles after the previous command.
- R7: A one-cycle `dll_rst` pulse sampled at edge E drops `rd_ok` to 0 after E, or keeps it at 0. `rd_ok` rises exactly LOCK_CYC edges after E, unless a further DLL event occurs first.
- R8: `sref_enter` drops `rd_ok` after the edge that samples it, and `rd_ok` stays 0 for any length of time until `sref_exit`. `sref_exit` then starts a full LOCK_CYC lockout, as R7 describes. If `sref_enter` and a re-enable event are sampled on the same edge, `sref_enter` wins.
- R9: A `dll_rst` pulse while `rd_ok` is 1 drops `rd_ok` and restarts the full lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_sel | input | 1 | 0: second extended register, 1: third |
| req_hitemp | input | 1 | High-temperature self-refresh rate enable (second register only) |
| banks_idle | input | 1 | All banks are precharged |
| cke_high | input | 1 | Clock enable to the memory is high |
| dll_rst | input | 1 | DLL enabled and reset (one-cycle pulse) |
| sref_enter | input | 1 | Memory enters self-refresh (pulse) |
| sref_exit | input | 1 | Memory leaves self-refresh (pulse) |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| bank | output | 2 | Bank address pins |
| addr | output | 14 | Address pins A0 to A13 |
| busy | output | 1 | Command spacing is still running |
| rd_ok | output | 1 | Reads are permitted |

## Verification
The bench builds the block with T_MRD = 4 and LOCK_CYC = 12. With a spacing of four, a back-to-back request has to wait through three busy cycles. That separates an exact spacing from an off-by-one counter, which a spacing of two would hide. A lockout of twelve cycles lets the bench sample both sides of the rising edge of `rd_ok` after a DLL reset, after a self-refresh exit and after a restart of a lockout already complete, all within a short run. The default lockout of 200 would only lengthen those waits.

// File: rtl/xmr_pkg.sv
package xmr_pkg;

  // A0..A13 on the memory side
  localparam int ADDR_W = 14;
  localparam int BANK_W = 2;
  // address bit carrying the high-temperature self-refresh rate enable
  localparam int HT_BIT = 7;

  typedef enum logic {
    SEL_EXT2 = 1'b0,
    SEL_EXT3 = 1'b1
  } xmr_sel_e;

  typedef enum logic [1:0] {
    DLL_OFF  = 2'd0,
    DLL_LOCK = 2'd1,
    DLL_RDY  = 2'd2
  } dll_state_e;

  typedef struct packed {
    logic              cs_n;
    logic              ras_n;
    logic              cas_n;
    logic              we_n;
    logic [BANK_W-1:0] bank;
    logic [ADDR_W-1:0] addr;
  } xmr_cmd_t;

  localparam xmr_cmd_t CMD_IDLE = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1,
                                    we_n: 1'b1, bank: '0, addr: '0};

  function automatic logic [BANK_W-1:0] xmr_bank(input xmr_sel_e sel);
    return (sel == SEL_EXT3) ? 2'b11 : 2'b10;
  endfunction

  function automatic logic [ADDR_W-1:0] xmr_addr(input xmr_sel_e sel,
                                                 input logic hitemp);
    logic [ADDR_W-1:0] a;
    a = '0;
    if (sel == SEL_EXT2) a[HT_BIT] = hitemp;
    return a;
  endfunction

endpackage

// File: rtl/xmr_cmd_enc.sv
module xmr_cmd_enc
  import xmr_pkg::*;
(
  input  logic     sel,
  input  logic     hitemp,
  output xmr_cmd_t cmd
);
  xmr_sel_e sel_e;

  always_comb begin
    sel_e     = xmr_sel_e'(sel);
    cmd       = CMD_IDLE;
    cmd.cs_n  = 1'b0;
    cmd.ras_n = 1'b0;
    cmd.cas_n = 1'b0;
    cmd.we_n  = 1'b0;
    cmd.bank  = xmr_bank(sel_e);
    cmd.addr  = xmr_addr(sel_e, hitemp);
  end
endmodule

// File: rtl/xmr_gap_timer.sv
module xmr_gap_timer #(
  parameter int T_MRD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  generate
    if (T_MRD <= 1) begin : g_nogap
      assign busy = 1'b0;
    end else begin : g_gap
      localparam int CW = $clog2(T_MRD);
      localparam logic [CW-1:0] LOAD = CW'(T_MRD - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= LOAD;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
      end
      assign busy = (cnt != '0);
    end
  endgenerate
endmodule

// File: rtl/xmr_dll_lock.sv
module xmr_dll_lock
  import xmr_pkg::*;
#(
  parameter int LOCK_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dll_rst,
  input  logic sref_enter,
  input  logic sref_exit,
  output logic rd_ok
);
  localparam int CW = $clog2(LOCK_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(LOCK_CYC - 1);

  dll_state_e    st;
  logic [CW-1:0] cnt;
  logic          relock;

  assign relock = dll_rst | sref_exit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= DLL_OFF;
      cnt <= '0;
    end else if (sref_enter) begin
      st  <= DLL_OFF;
      cnt <= '0;
    end else if (relock) begin
      st  <= DLL_LOCK;
      cnt <= LOAD;
    end else if (st == DLL_LOCK) begin
      if (cnt == '0) st  <= DLL_RDY;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign rd_ok = (st == DLL_RDY);
endmodule

// File: rtl/ddr2_xmr_seq.sv
module ddr2_xmr_seq
  import xmr_pkg::*;
#(
  parameter int T_MRD    = 2,
  parameter int LOCK_CYC = 200
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_sel,
  input  logic                req_hitemp,
  input  logic                banks_idle,
  input  logic                cke_high,
  input  logic                dll_rst,
  input  logic                sref_enter,
  input  logic                sref_exit,
  output logic                cs_n,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic [BANK_W-1:0]   bank,
  output logic [ADDR_W-1:0]   addr,
  output logic                busy,
  output logic                rd_ok
);
  // named internal events for the checker
  logic     accept;
  logic     cmd_legal;
  xmr_cmd_t enc_cmd;
  xmr_cmd_t cmd_q;

  assign cmd_legal = banks_idle & cke_high;
  assign req_ready = cmd_legal & ~busy;
  assign accept    = req_valid & req_ready;

  xmr_cmd_enc u_enc (
    .sel    (req_sel),
    .hitemp (req_hitemp),
    .cmd    (enc_cmd)
  );

  xmr_gap_timer #(.T_MRD(T_MRD)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .busy  (busy)
  );

  xmr_dll_lock #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .dll_rst    (dll_rst),
    .sref_enter (sref_enter),
    .sref_exit  (sref_exit),
    .rd_ok      (rd_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      cmd_q <= CMD_IDLE;
    else if (accept) cmd_q <= enc_cmd;
    else             cmd_q <= CMD_IDLE;
  end

  assign cs_n  = cmd_q.cs_n;
  assign ras_n = cmd_q.ras_n;
  assign cas_n = cmd_q.cas_n;
  assign we_n  = cmd_q.we_n;
  assign bank  = cmd_q.bank;
  assign addr  = cmd_q.addr;
endmodule

// File: rtl/xmr_seq_checker.sv
module xmr_seq_checker
  import xmr_pkg::*;
#(
  parameter int T_MRD    = 2,
  parameter int LOCK_CYC = 200
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              banks_idle,
  input logic              cke_high,
  input logic              dll_rst,
  input logic              sref_enter,
  input logic              sref_exit,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BANK_W-1:0] bank,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              rd_ok,
  input logic              accept
);
  localparam int LW = $clog2(LOCK_CYC + 2);
  localparam logic [LW-1:0] LSAT = LW'(LOCK_CYC + 1);
  localparam logic [LW-1:0] LEXP = LW'(LOCK_CYC);

  // cycles since the last DLL re-enable, saturating
  logic [LW-1:0] since_en;
  always_ff @(posedge clk) begin
    if (!rst_n)                                 since_en <= LSAT;
    else if (sref_enter)                        since_en <= LSAT;
    else if (dll_rst || sref_exit)              since_en <= '0;
    else if (since_en != LSAT)                  since_en <= since_en + 1'b1;
  end

  assert_strobes_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == ras_n) && (cs_n == cas_n) && (cs_n == we_n));

  assert_cmd_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cs_n);

  assert_cmd_needs_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> cs_n);

  assert_bank_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> bank[1]);

  assert_ext3_addr_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && bank == 2'b11) |-> addr == '0);

  assert_ext2_addr_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && bank == 2'b10) |-> (addr & ~(ADDR_W'(1) << HT_BIT)) == '0);

  assert_idle_pins_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (addr == '0 && bank == '0));

  assert_accept_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (banks_idle && cke_high && req_valid));

  assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  generate
    if (T_MRD >= 2) begin : g_sp
      assert_busy_on_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);
      assert_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> cs_n);
    end
  endgenerate

  assert_lockout_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_ok) |-> since_en == LEXP);

  assert_sref_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sref_enter |=> !rd_ok);

  assert_restart_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dll_rst |=> !rd_ok);
endmodule

bind ddr2_xmr_seq xmr_seq_checker #(.T_MRD(T_MRD), .LOCK_CYC(LOCK_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .banks_idle(banks_idle), .cke_high(cke_high), .dll_rst(dll_rst),
  .sref_enter(sref_enter), .sref_exit(sref_exit), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .bank(bank), .addr(addr), .busy(busy),
  .rd_ok(rd_ok), .accept(accept)
);

// File: tb/ddr2_xmr_seq_bench.sv
module ddr2_xmr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TM = 4;
  localparam int LK = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_sel = 1'b0, req_hitemp = 1'b0;
  logic banks_idle = 1'b1, cke_high = 1'b1;
  logic dll_rst = 1'b0, sref_enter = 1'b0, sref_exit = 1'b0;
  logic req_ready, cs_n, ras_n, cas_n, we_n, busy, rd_ok;
  logic [1:0]  bank;
  logic [13:0] addr;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr2_xmr_seq #(.T_MRD(TM), .LOCK_CYC(LK)) u_ddr2_xmr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_hitemp(req_hitemp), .banks_idle(banks_idle),
    .cke_high(cke_high), .dll_rst(dll_rst), .sref_enter(sref_enter),
    .sref_exit(sref_exit), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .bank(bank), .addr(addr), .busy(busy), .rd_ok(rd_ok)
  );

  typedef struct packed {
    logic        sel;
    logic        ht;
    logic [1:0]  ba;
    logic [13:0] ad;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{sel: 1'b0, ht: 1'b0, ba: 2'b10, ad: 14'h0000},
    '{sel: 1'b0, ht: 1'b1, ba: 2'b10, ad: 14'h0080},
    '{sel: 1'b1, ht: 1'b1, ba: 2'b11, ad: 14'h0000},
    '{sel: 1'b1, ht: 1'b0, ba: 2'b11, ad: 14'h0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] strobes();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  // offer a request; returns at the negedge of the command cycle
  task automatic issue(input logic sel, input logic ht);
    @(negedge clk);
    req_valid = 1'b1; req_sel = sel; req_hitemp = ht;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic lockout_window(input string tag);
    check({tag, " low just after event"}, 32'(rd_ok), 32'd0);
    repeat (LK - 1) @(negedge clk);
    check({tag, " low one cycle before end"}, 32'(rd_ok), 32'd0);
    @(negedge clk);
    check({tag, " high at end of lockout"}, 32'(rd_ok), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int c_prev;
    repeat (3) @(negedge clk);
    check("R1 strobes in reset", 32'(strobes()), 32'hF);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 strobes idle", 32'(strobes()), 32'hF);
    check("R1 bank/addr zero", {16'd0, bank, addr}, 32'd0);
    check("R1 busy low", 32'(busy), 32'd0);
    check("R1 rd_ok low", 32'(rd_ok), 32'd0);

    // table walk: R2 R3 R4 R6
    foreach (VECS[i]) begin
      issue(VECS[i].sel, VECS[i].ht);
      check("R2 strobes low in cmd cycle", 32'(strobes()), 32'h0);
      check("R3 bank code", 32'(bank), 32'(VECS[i].ba));
      check("R4 address bits", 32'(addr), 32'(VECS[i].ad));
      check("R6 busy in cmd cycle", 32'(busy), 32'd1);
      @(negedge clk);
      check("R2 strobes high after cmd", 32'(strobes()), 32'hF);
      check("R4 idle address zero", {16'd0, bank, addr}, 32'd0);
      repeat (TM - 2) @(negedge clk);
      check("R6 busy low after spacing", 32'(busy), 32'd0);
    end

    // back-to-back spacing: R6
    issue(1'b0, 1'b1);
    c_prev = cyc;
    check("R6 ready low while busy", 32'(req_ready), 32'd0);
    issue(1'b1, 1'b0);
    check("R6 second cmd spacing", 32'(cyc - c_prev), 32'(TM));
    check("R6 second cmd strobes", 32'(strobes()), 32'h0);
    repeat (TM) @(negedge clk);

    // precondition gating: R5
    banks_idle = 1'b0;
    req_valid = 1'b1; req_sel = 1'b0; req_hitemp = 1'b1;
    repeat (5) begin
      @(negedge clk);
      check("R5 ready low banks open", 32'(req_ready), 32'd0);
      check("R5 no cmd banks open", 32'(cs_n), 32'd1);
    end
    banks_idle = 1'b1; cke_high = 1'b0;
    repeat (5) begin
      @(negedge clk);
      check("R5 ready low cke low", 32'(req_ready), 32'd0);
      check("R5 no cmd cke low", 32'(cs_n), 32'd1);
    end
    cke_high = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R5 held request issued", 32'(strobes()), 32'h0);
    check("R5 held request address", 32'(addr), 32'h0080);
    repeat (TM) @(negedge clk);

    // lockout: R7 R8 R9
    check("R7 rd_ok low before DLL enable", 32'(rd_ok), 32'd0);
    pulse(dll_rst);
    lockout_window("R7 dll enable");
    pulse(dll_rst);
    lockout_window("R9 restart while ready");
    pulse(sref_enter);
    check("R8 drop on self-refresh entry", 32'(rd_ok), 32'd0);
    repeat (3 * LK) @(negedge clk);
    check("R8 stays low in self-refresh", 32'(rd_ok), 32'd0);
    pulse(sref_exit);
    lockout_window("R8 self-refresh exit");
    // simultaneous entry and re-enable: entry wins
    @(negedge clk); sref_enter = 1'b1; dll_rst = 1'b1;
    @(negedge clk); sref_enter = 1'b0; dll_rst = 1'b0;
    repeat (LK + 2) @(negedge clk);
    check("R8 entry wins over re-enable", 32'(rd_ok), 32'd0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule